// File: doc/BRIEF.md
# Mode-Banked Register File with Status Word

This block stores the sixteen visible 32-bit general registers of a processor core together with its current status word. Which physical storage cell a register index reaches depends on the operating mode held in the low five bits of the status word. Indices 13 and 14 hold the stack pointer and the link register, and each privileged mode that is entered through an exception has its own copy of both. Every other index, including the program counter at index 15, is one cell that all modes share. User and system mode share one bank.

The core reads two operands through combinational read ports and writes one result per clock. The status word has a read/write port that checks privilege. A separate port reads and writes the saved copy of the status word for the current mode. An exception-entry strobe saves the status word into the target mode's saved copy, switches the mode and raises the interrupt masks. A return strobe copies the current mode's saved copy back into the status word, which also brings back the earlier bank.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word is 0x000000D3. This is supervisor mode (code 10011 in bits 4..0) with the interrupt mask bit 7 and the fast-interrupt mask bit 6 set. Every saved status copy reads as zero.
- R2: Both read ports are combinational. A register write takes effect on the next rising edge. A read of the index being written in the same cycle returns the old value.
- R3: Indices 0..12 and 15 reach one shared cell each. Indices 13 and 14 reach a separate pair for each of fast interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011). User (10000) and system (11111) use one common pair.
- R4: In a privileged mode (any of the six codes other than user) a status write replaces the whole word. In user mode only bits 31..24 (the flags) change and bits 23..0 stay as they were.
- R5: A status write that changes the mode switches the bank at once and leaves every saved status copy unchanged.
- R6: When exception entry is strobed with one of the five banked codes, the old status word is copied into that mode's saved copy. The mode field takes the new code, bit 7 is set, the state bit 5 is cleared and all other bits are kept. Bit 6 is also set when the code is fast interrupt. Entry with any other code has no effect.
- R7: A return strobe in a banked mode loads the status word from that mode's saved copy. In user or system mode it has no effect.
- R8: In user or system mode the saved-status read port returns zero and writes to it are ignored.
- R9: A mode code outside the seven listed ones banks like user mode and is unprivileged.
- R10: When several strobes arrive in the same cycle, reset wins over exception entry. Exception entry wins over return. Return wins over a status write or a saved-status write, and the losing strobes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| psr_wr_en | input | 1 | Status word write strobe |
| psr_wr_data | input | 32 | Status word write data |
| psr_rd_data | output | 32 | Current status word |
| spsr_wr_en | input | 1 | Saved status write strobe for the current mode |
| spsr_wr_data | input | 32 | Saved status write data |
| spsr_rd_data | output | 32 | Saved status word of the current mode |
| exc_en | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Mode code entered on exception |
| ret_en | input | 1 | Exception return strobe |

## Verification
The properties assume that reset is held through the first rising edge, so the status word is defined before any property is sampled. They also assume that strobes are only sampled at clock edges. The entry and return properties compare the word one cycle later with the values seen at the strobe, so they rely on the precedence in R10. Each property names the competing strobes in its antecedent. The bench changes inputs one time unit after a rising edge and returns every strobe to zero after one cycle. It drives competing strobes together only in the scenario that checks R10.

// File: rtl/brf_pkg.sv
package brf_pkg;

  localparam int MODE_W = 5;
  localparam int BANK_W = 3;
  localparam int NBANK  = 6;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam int BIT_IMASK = 7;
  localparam int BIT_FMASK = 6;
  localparam int BIT_STATE = 5;
  localparam int FLAG_LO   = 24;

  // bank 0 is shared by user, system and any unknown code
  function automatic logic [BANK_W-1:0] bank_of(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: bank_of = 3'd1;
      MODE_IRQ: bank_of = 3'd2;
      MODE_SVC: bank_of = 3'd3;
      MODE_ABT: bank_of = 3'd4;
      MODE_UND: bank_of = 3'd5;
      default:  bank_of = 3'd0;
    endcase
  endfunction

  function automatic logic is_priv(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND, MODE_SYS: is_priv = 1'b1;
      default: is_priv = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/brf_bank_map.sv
module brf_bank_map
  import brf_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PHYS_W = 5
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);
  localparam int SP_IDX = 13;
  localparam int LR_IDX = 14;
  localparam int PC_IDX = 15;
  localparam int BANKED_BASE = 14;

  logic [BANK_W-1:0] bk;
  int unsigned slot;

  assign bk = bank_of(mode);

  always_comb begin
    slot = 0;
    if (int'(idx) == SP_IDX || int'(idx) == LR_IDX)
      slot = BANKED_BASE + 2 * int'(bk) + (int'(idx) - SP_IDX);
    else if (int'(idx) == PC_IDX)
      slot = SP_IDX;
    else
      slot = int'(idx);
    phys = PHYS_W'(slot);
  end

endmodule

// File: rtl/brf_gpr_store.sv
module brf_gpr_store #(
  parameter int DATA_W = 32,
  parameter int NPHYS  = 26,
  parameter int PHYS_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PHYS_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PHYS_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [PHYS_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] cells [NPHYS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/brf_status.sv
module brf_status
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psr_wr_en,
  input  logic [DATA_W-1:0] psr_wr_data,
  input  logic              spsr_wr_en,
  input  logic [DATA_W-1:0] spsr_wr_data,
  input  logic              exc_en,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic              ret_en,
  output logic [DATA_W-1:0] psr,
  output logic [DATA_W-1:0] spsr
);
  localparam logic [DATA_W-1:0] RESET_WORD =
    DATA_W'(MODE_SVC) | (DATA_W'(1) << BIT_IMASK) | (DATA_W'(1) << BIT_FMASK);

  logic [DATA_W-1:0] psr_q;
  logic [DATA_W-1:0] saved_q [NBANK];
  logic [BANK_W-1:0] cur_bk, exc_bk;
  logic              cur_priv;
  logic [DATA_W-1:0] entry_word, sw_word;

  assign cur_bk   = bank_of(psr_q[MODE_W-1:0]);
  assign exc_bk   = bank_of(exc_mode);
  assign cur_priv = is_priv(psr_q[MODE_W-1:0]);

  always_comb begin
    entry_word = psr_q;
    entry_word[MODE_W-1:0] = exc_mode;
    entry_word[BIT_IMASK]  = 1'b1;
    entry_word[BIT_STATE]  = 1'b0;
    if (exc_mode == MODE_FIQ) entry_word[BIT_FMASK] = 1'b1;
  end

  always_comb begin
    if (cur_priv) sw_word = psr_wr_data;
    else          sw_word = {psr_wr_data[DATA_W-1:FLAG_LO], psr_q[FLAG_LO-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_q <= RESET_WORD;
      for (int b = 0; b < NBANK; b++) saved_q[b] <= '0;
    end else if (exc_en && exc_bk != '0) begin
      psr_q <= entry_word;
      for (int b = 1; b < NBANK; b++)
        if (int'(exc_bk) == b) saved_q[b] <= psr_q;
    end else if (ret_en && cur_bk != '0) begin
      psr_q <= saved_q[cur_bk];
    end else begin
      if (psr_wr_en) psr_q <= sw_word;
      for (int b = 1; b < NBANK; b++)
        if (spsr_wr_en && int'(cur_bk) == b) saved_q[b] <= spsr_wr_data;
    end
  end

  assign psr  = psr_q;
  assign spsr = (int'(cur_bk) < NBANK) ? saved_q[cur_bk] : '0;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              psr_wr_en,
  input  logic [DATA_W-1:0] psr_wr_data,
  output logic [DATA_W-1:0] psr_rd_data,
  input  logic              spsr_wr_en,
  input  logic [DATA_W-1:0] spsr_wr_data,
  output logic [DATA_W-1:0] spsr_rd_data,
  input  logic              exc_en,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic              ret_en
);
  localparam int NSHARED = (1 << IDX_W) - 2;
  localparam int NPHYS   = NSHARED + 2 * NBANK;
  localparam int PHYS_W  = $clog2(NPHYS);
  localparam int NPORT   = 3;

  logic [MODE_W-1:0] cur_mode;
  logic [IDX_W-1:0]  map_idx  [NPORT];
  logic [PHYS_W-1:0] map_phys [NPORT];

  assign cur_mode   = psr_rd_data[MODE_W-1:0];
  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    brf_bank_map #(.IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_map (
      .mode (cur_mode),
      .idx  (map_idx[p]),
      .phys (map_phys[p])
    );
  end

  brf_gpr_store #(.DATA_W(DATA_W), .NPHYS(NPHYS), .PHYS_W(PHYS_W)) u_store (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (map_phys[2]),
    .wdata   (wr_data),
    .raddr_a (map_phys[0]),
    .rdata_a (rd_a_data),
    .raddr_b (map_phys[1]),
    .rdata_b (rd_b_data)
  );

  brf_status #(.DATA_W(DATA_W)) u_status (
    .clk          (clk),
    .rst          (rst),
    .psr_wr_en    (psr_wr_en),
    .psr_wr_data  (psr_wr_data),
    .spsr_wr_en   (spsr_wr_en),
    .spsr_wr_data (spsr_wr_data),
    .exc_en       (exc_en),
    .exc_mode     (exc_mode),
    .ret_en       (ret_en),
    .psr          (psr_rd_data),
    .spsr         (spsr_rd_data)
  );

endmodule

module brf_chk
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              psr_wr_en,
  input logic [DATA_W-1:0] psr_rd_data,
  input logic [DATA_W-1:0] spsr_rd_data,
  input logic              exc_en,
  input logic [MODE_W-1:0] exc_mode,
  input logic              ret_en
);
  // R6
  exc_entry_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_en && bank_of(exc_mode) != '0) |=>
      (psr_rd_data[MODE_W-1:0] == $past(exc_mode)) && psr_rd_data[BIT_IMASK] && !psr_rd_data[BIT_STATE]);

  // R6
  exc_entry_save_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_en && bank_of(exc_mode) != '0) |=> (spsr_rd_data == $past(psr_rd_data)));

  // R7
  ret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !exc_en && bank_of(psr_rd_data[MODE_W-1:0]) != '0) |=> (psr_rd_data == $past(spsr_rd_data)));

  // R4
  user_ctl_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (psr_wr_en && !exc_en && !ret_en && !is_priv(psr_rd_data[MODE_W-1:0])) |=>
      (psr_rd_data[FLAG_LO-1:0] == $past(psr_rd_data[FLAG_LO-1:0])));

  // R8
  no_saved_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_of(psr_rd_data[MODE_W-1:0]) == '0) |-> (spsr_rd_data == '0));

endmodule

bind banked_regfile brf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .psr_wr_en    (psr_wr_en),
  .psr_rd_data  (psr_rd_data),
  .spsr_rd_data (spsr_rd_data),
  .exc_en       (exc_en),
  .exc_mode     (exc_mode),
  .ret_en       (ret_en)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, psr_wr_en = 1'b0, spsr_wr_en = 1'b0;
  logic [31:0] psr_wr_data = '0, psr_rd_data, spsr_wr_data = '0, spsr_rd_data;
  logic        exc_en = 1'b0, ret_en = 1'b0;
  logic [4:0]  exc_mode = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data), .psr_rd_data(psr_rd_data),
    .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_rd_data(spsr_rd_data),
    .exc_en(exc_en), .exc_mode(exc_mode), .ret_en(ret_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_strobes();
    wr_en = 0; psr_wr_en = 0; spsr_wr_en = 0; exc_en = 0; ret_en = 0;
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d;
    tick(); clear_strobes();
  endtask

  function automatic logic [31:0] rd_reg(input logic [3:0] i);
    return 32'h0;
  endfunction

  task automatic read_a(input logic [3:0] i, output logic [31:0] d);
    rd_a_idx = i; #1; d = rd_a_data;
  endtask

  task automatic wr_psr(input logic [31:0] d);
    psr_wr_en = 1; psr_wr_data = d;
    tick(); clear_strobes();
  endtask

  task automatic enter(input logic [4:0] m);
    exc_en = 1; exc_mode = m;
    tick(); clear_strobes();
  endtask

  task automatic leave();
    ret_en = 1;
    tick(); clear_strobes();
  endtask

  task automatic t_reset();
    check("R1 reset status", psr_rd_data, 32'h0000_00D3);
    check("R1 reset saved copy", spsr_rd_data, 32'h0);
  endtask

  task automatic t_rw();
    logic [31:0] v;
    wr_reg(4'd0, 32'h0000_00A1);
    read_a(4'd0, v);
    check("R2 write then read", v, 32'h0000_00A1);
    wr_en = 1; wr_idx = 4'd0; wr_data = 32'h0000_00B2; rd_a_idx = 4'd0; #1;
    check("R2 same-cycle read old", rd_a_data, 32'h0000_00A1);
    tick(); clear_strobes();
    check("R2 value after edge", rd_a_data, 32'h0000_00B2);
    wr_reg(4'd15, 32'h0000_C0DE);
    rd_b_idx = 4'd15; #1;
    check("R2 port b reads pc", rd_b_data, 32'h0000_C0DE);
  endtask

  task automatic t_bank();
    logic [31:0] v;
    wr_reg(4'd13, 32'h0000_5C13);
    wr_reg(4'd14, 32'h0000_5C14);
    wr_psr(32'h0000_0010);
    check("R4 privileged full write", psr_rd_data, 32'h0000_0010);
    wr_reg(4'd13, 32'h0000_0513);
    read_a(4'd13, v);
    check("R3 user sp", v, 32'h0000_0513);
    read_a(4'd15, v);
    check("R3 pc shared", v, 32'h0000_C0DE);
    enter(5'b10011);
    check("R6 entry to supervisor", psr_rd_data, 32'h0000_0093);
    check("R6 saved word", spsr_rd_data, 32'h0000_0010);
    read_a(4'd13, v);
    check("R3 supervisor sp kept", v, 32'h0000_5C13);
    read_a(4'd14, v);
    check("R3 supervisor lr kept", v, 32'h0000_5C14);
    read_a(4'd0, v);
    check("R3 r0 shared", v, 32'h0000_00B2);
    leave();
    check("R7 return restores", psr_rd_data, 32'h0000_0010);
    read_a(4'd13, v);
    check("R7 user sp back", v, 32'h0000_0513);
  endtask

  task automatic t_user();
    wr_psr(32'hF000_00D3);
    check("R4 user writes only flags", psr_rd_data, 32'hF000_0010);
    spsr_wr_en = 1; spsr_wr_data = 32'hDEAD_BEEF; tick(); clear_strobes();
    check("R8 user saved read zero", spsr_rd_data, 32'h0);
    leave();
    check("R7 return in user ignored", psr_rd_data, 32'hF000_0010);
    enter(5'b10000);
    check("R6 entry with user code ignored", psr_rd_data, 32'hF000_0010);
  endtask

  task automatic t_irq_fiq();
    logic [31:0] v;
    enter(5'b10010);
    check("R6 irq entry word", psr_rd_data, 32'hF000_0092);
    check("R6 irq saved", spsr_rd_data, 32'hF000_0010);
    wr_reg(4'd13, 32'h0000_1213);
    read_a(4'd13, v);
    check("R3 irq sp", v, 32'h0000_1213);
    leave();
    check("R7 irq return", psr_rd_data, 32'hF000_0010);
    read_a(4'd13, v);
    check("R3 user sp untouched by irq", v, 32'h0000_0513);
    enter(5'b10001);
    check("R6 fiq entry sets both masks", psr_rd_data, 32'hF000_00D1);
    leave();
    check("R7 fiq return", psr_rd_data, 32'hF000_0010);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    enter(5'b11011);
    check("R6 und entry", psr_rd_data, 32'hF000_009B);
    wr_psr(32'h0000_0097);
    check("R5 direct switch to abort", psr_rd_data, 32'h0000_0097);
    check("R5 abort saved not copied", spsr_rd_data, 32'h0);
    wr_psr(32'h0000_009B);
    check("R5 und saved unchanged", spsr_rd_data, 32'hF000_0010);
    wr_psr(32'h0000_001F);
    read_a(4'd13, v);
    check("R3 system uses user sp", v, 32'h0000_0513);
    check("R8 system saved zero", spsr_rd_data, 32'h0);
    spsr_wr_en = 1; spsr_wr_data = 32'h1234_5678; tick(); clear_strobes();
    check("R8 system saved write ignored", spsr_rd_data, 32'h0);
  endtask

  task automatic t_invalid();
    logic [31:0] v;
    wr_psr(32'h0000_0015);
    check("R9 unknown code accepted", psr_rd_data, 32'h0000_0015);
    read_a(4'd13, v);
    check("R9 unknown code banks as user", v, 32'h0000_0513);
    wr_psr(32'h2000_0013);
    check("R9 unknown code unprivileged", psr_rd_data, 32'h2000_0015);
  endtask

  task automatic t_priority();
    exc_en = 1; exc_mode = 5'b10010; psr_wr_en = 1; psr_wr_data = 32'h0;
    tick(); clear_strobes();
    check("R10 entry beats status write", psr_rd_data, 32'h2000_0092);
    check("R10 entry saved", spsr_rd_data, 32'h2000_0015);
    ret_en = 1; psr_wr_en = 1; psr_wr_data = 32'h0000_0013;
    spsr_wr_en = 1; spsr_wr_data = 32'h0;
    tick(); clear_strobes();
    check("R10 return beats status write", psr_rd_data, 32'h2000_0015);
    rst = 1; exc_en = 1; exc_mode = 5'b10111;
    tick(); clear_strobes(); rst = 0;
    check("R10 reset beats entry", psr_rd_data, 32'h0000_00D3);
    check("R1 saved cleared by reset", spsr_rd_data, 32'h0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    t_reset();
    t_rw();
    t_bank();
    t_user();
    t_irq_fiq();
    t_direct();
    t_invalid();
    t_priority();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule